// File: doc/BRIEF.md
# Prescaled Fractional Baud Tick Generator

This block turns a fast system clock into a stream of single-cycle baud ticks for a UART serializer. Two cascaded stages set the rate. An integer prescaler divides the clock by `scale + 1`. A 17-bit phase accumulator then adds a 16-bit `step` on each prescaler pulse. Each time the accumulator wraps past 2^17, the block emits a tick. The resulting average tick rate is clk / (scale + 1) * step / 2^17. This allows a fractional divide ratio with fine resolution.

Software presents new settings on `cfg_scale` and `cfg_step` and strobes `cfg_load`. The load captures both fields and clears the two counting stages, so the new rate starts from a clean phase. A `restart` strobe clears the counters but keeps the settings. Lowering `enable` freezes the counters and blocks ticks.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick` is 0, the captured scale and step are both 0, and both counters are at zero.
- R2: With `enable` held high, the prescaler completes one period every `scale + 1` enabled cycles, counted from the last clear. A tick can appear only in the last cycle of a period.
- R3: Number the completed prescaler periods p = 1, 2, ... from the last clear. `tick` is 1 in the last cycle of period p exactly when floor(p*step / 2^17) > floor((p-1)*step / 2^17). The tick is combinational in that same cycle.
- R4: A captured step of 0 produces no tick.
- R5: In a cycle with `cfg_load` = 1, `tick` is 0. At the clock edge the block captures `cfg_scale` and `cfg_step`, and both counters return to zero.
- R6: In a cycle with `restart` = 1, `tick` is 0. Both counters return to zero while the captured settings are kept.
- R7: While `enable` = 0, `tick` is 0 and neither counter advances. Counting resumes from the held state.
- R8: `tick` is never 1 in two consecutive cycles, for every scale (including 0) and every step up to 0xFFFF.
- R9: The extreme settings follow R2 and R3. These are scale = 4095 (a divide-by-4096 prescaler) and step = 0xFFFF with scale = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows counting and ticks when 1 |
| restart | input | 1 | Clears both counters, keeps settings |
| cfg_load | input | 1 | Captures scale and step, clears both counters |
| cfg_scale | input | SCALE_W (12) | Prescaler divide value minus one |
| cfg_step | input | STEP_W (16) | Accumulator increment per prescaler period |
| tick | output | 1 | One-cycle baud tick |

## Verification
Random pairs of small scale and random step values are run with enable mostly high. This separates errors in the prescaler period from errors in the accumulator carry, because the bench predicts the exact tick cycle from the period count. Random enable drops and restart strobes show whether the counters hold or clear the phase correctly. Directed runs with step 0, step 0xFFFF at scale 0, and scale 4095 check the edges: no ticks, the densest possible tick pattern, and the widest prescaler.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int SCALE_W = 12,
  parameter int STEP_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               restart,
  input  logic               cfg_load,
  input  logic [SCALE_W-1:0] cfg_scale,
  input  logic [STEP_W-1:0]  cfg_step,
  output logic               tick
);
  localparam int ACC_W = STEP_W + 1;

  logic [SCALE_W-1:0] scale_q;
  logic [SCALE_W-1:0] pre_cnt;
  logic [STEP_W-1:0]  step_q;
  logic [ACC_W-1:0]   acc_q;
  logic [ACC_W:0]     acc_sum;
  logic               clear;
  logic               pre_wrap;
  logic               advance;

  assign clear    = restart | cfg_load;
  assign pre_wrap = (pre_cnt == scale_q);
  assign advance  = enable & ~clear & pre_wrap;
  assign acc_sum  = {1'b0, acc_q} + {2'b00, step_q};
  assign tick     = advance & acc_sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q <= '0;
      step_q  <= '0;
      pre_cnt <= '0;
      acc_q   <= '0;
    end else begin
      if (cfg_load) begin
        scale_q <= cfg_scale;
        step_q  <= cfg_step;
      end
      if (clear) begin
        pre_cnt <= '0;
        acc_q   <= '0;
      end else if (enable) begin
        pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
        if (pre_wrap) acc_q <= acc_sum[ACC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int SCALE_W = 12,
  parameter int STEP_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               restart,
  input logic               cfg_load,
  input logic               tick,
  input logic [SCALE_W-1:0] pre_cnt,
  input logic [SCALE_W-1:0] scale_q,
  input logic [STEP_W-1:0]  step_q
);
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !tick);
  a_r5_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (pre_cnt == '0));
  a_r6_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !cfg_load) |=> (pre_cnt == '0 && $stable(scale_q) && $stable(step_q)));
  a_r4_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == '0) |-> !tick);
  a_r2_tick_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (pre_cnt == scale_q));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !restart && !cfg_load) |=> $stable(pre_cnt));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
  .cfg_load(cfg_load), .tick(tick), .pre_cnt(pre_cnt),
  .scale_q(scale_q), .step_q(step_q)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        enable = 0;
  logic        restart = 0;
  logic        cfg_load = 0;
  logic [11:0] cfg_scale = '0;
  logic [15:0] cfg_step = '0;
  logic        tick;

  int checks = 0;
  int failures = 0;
  longint m_n = 0;
  longint m_s = 0;
  longint m_k = 0;
  logic prev_tick = 0;
  string phase = "R3";
  bit done = 0;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
    .cfg_load(cfg_load), .cfg_scale(cfg_scale), .cfg_step(cfg_step), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_tick(longint n, longint s, longint k);
    longint p;
    if (n % (s + 1) != 0) return 0;
    p = n / (s + 1);
    return ((p * k) >> 17) != (((p - 1) * k) >> 17);
  endfunction

  task automatic check(bit got, bit exp, string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: tick actual=%0b expected=%0b (n=%0d scale=%0d step=%0d)",
               req, got, exp, m_n, m_s, m_k);
    end
  endtask

  task automatic cyc(bit en, bit rs, bit ld, logic [11:0] sc, logic [15:0] st);
    bit e;
    string tag;
    enable = en; restart = rs; cfg_load = ld; cfg_scale = sc; cfg_step = st;
    #1;
    if (ld) begin e = 0; tag = "R5"; end
    else if (rs) begin e = 0; tag = "R6"; end
    else if (!en) begin e = 0; tag = "R7"; end
    else begin
      e = exp_tick(m_n + 1, m_s, m_k);
      if (m_k == 0) tag = "R4";
      else if ((m_n + 1) % (m_s + 1) != 0) tag = "R2";
      else tag = phase;
    end
    check(tick, e, tag);
    checks++;
    if (prev_tick && tick) begin
      failures++;
      $display("FAIL R8: tick actual=1 expected=0 in consecutive cycle");
    end
    prev_tick = tick;
    if (ld) begin m_s = sc; m_k = st; m_n = 0; end
    else if (rs) m_n = 0;
    else if (en) m_n++;
    @(negedge clk);
  endtask

  task automatic run(int cycles, logic [11:0] sc, logic [15:0] st, int pct_en, int pct_rs);
    cyc(1, 0, 1, sc, st);
    for (int i = 0; i < cycles; i++) begin
      bit en = ($urandom % 100) < pct_en;
      bit rs = ($urandom % 1000) < pct_rs;
      cyc(en, rs, 0, $urandom, $urandom);
    end
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    checks++;
    if (tick !== 1'b0) begin
      failures++;
      $display("FAIL R1: tick actual=%0b expected=0 in reset", tick);
    end
    rst_n = 1;
    // R1: after reset, step is 0, so no ticks
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 12'd3, 16'h1234);
    // R1: counting starts from zero after first load
    phase = "R1";
    run(200, 12'd0, 16'h4000, 100, 0);
    phase = "R3";
    for (int r = 0; r < 12; r++) begin
      run(2000, 12'($urandom % 8), 16'($urandom), 85, 3);
    end
    // R4: zero step
    run(3000, 12'd2, 16'h0000, 90, 2);
    // R9: densest setting, R8 consecutive check
    phase = "R9";
    run(3000, 12'd0, 16'hFFFF, 100, 0);
    run(3000, 12'd0, 16'hFFFF, 70, 5);
    // R9: widest prescaler
    run(34000, 12'd4095, 16'h8000, 100, 0);
    // R7: enable low hold then resume mid-period
    phase = "R7";
    cyc(1, 0, 1, 12'd5, 16'h9000);
    for (int i = 0; i < 500; i++) cyc((i % 7) != 3, 0, 0, 12'd9, 16'd1);
    // R6: restart keeps config
    phase = "R6";
    for (int i = 0; i < 500; i++) cyc(1, (i % 97) == 50, 0, 12'd0, 16'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule